// File: doc/BRIEF.md
# Write-Once Watchdog Timer with Sticky Reset Cause

This block guards a processor against a runaway program. A free-running counter advances on a selectable time base: either single-cycle ticks from a low-speed clock domain (already synchronised to the system clock) or every system clock cycle. Software must write the key byte 8'hAC to the restart register at regular intervals. If it fails to do so before the counter reaches the selected overflow length, the block raises an internal reset request for a fixed number of cycles. It also records the cause in a sticky flag that software reads after the restart.

The mode register sets the overflow length and the time base. It accepts exactly one write after each reset. Any later write is treated as a software fault, and so is any restart write carrying a value other than the key. A fault raises the same reset request as an overflow. A configuration strap can force the low-speed time base and keep the count running through standby. With the strap low, the halt and stop standby inputs freeze the count.

While the reset request is active, the block puts itself back into its post-reset state. The only exception is the cause flag, which survives. Only the external reset and a software read clear that flag.

Top module: `wdt_guard`

## Requirements
- R1: After the external reset, `rst_req` is 0, `flag_rdata` reads 0, the mode register is writable, the time base is the low-speed tick, and the overflow select holds its largest value (TAP_CNT-1).
- R2: From a count of zero, the reset request rises on the clock edge of the 2^(TAP_MIN+s)-th counting tick, where s is the effective overflow select. It then stays high for exactly RST_PULSE cycles, and bit FLAG_BIT (bit 4) of `flag_rdata` is set from the first of those cycles.
- R3: A mode write places the overflow select in `wr_data[SEL_W-1:0]` and the time base in `wr_data[4]` (1 selects every system clock, 0 selects `slow_tick`). All other data bits are ignored. A select value of TAP_CNT or more acts as TAP_CNT-1.
- R4: The first mode write after a reset is accepted silently and locks the register. Any further mode write raises the reset request in the next cycle.
- R5: A restart write of 8'hAC sets the count to zero, so the next overflow occurs only after a full interval measured from that write.
- R6: A restart write of any value other than 8'hAC raises the reset request in the next cycle.
- R7: With `strap_fixed` high, only `slow_tick` advances the count, whatever `wr_data[4]` held in the mode write, and the halt and stop inputs have no effect.
- R8: With `strap_fixed` low, the count does not advance while `halt_req` or `stop_req` is high, and it resumes from the held value afterwards.
- R9: `flag_rdata` shows the cause flag at bit FLAG_BIT and zero in every other bit. A cycle with `rd_flag` high clears it on the following edge unless a new fault is raised on that edge. The reset request itself never clears it.
- R10: During the reset request, the count is zero and write strobes are ignored. When the request ends, the mode register is unlocked and holds its post-reset defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| slow_tick | input | 1 | One-cycle tick from the low-speed time base |
| strap_fixed | input | 1 | Strap: force low-speed base, run through standby |
| halt_req | input | 1 | Halt standby state |
| stop_req | input | 1 | Stop standby state |
| wr_mode | input | 1 | Write strobe for the mode register |
| wr_key | input | 1 | Write strobe for the restart register |
| wr_data | input | 8 | Write data for either register |
| rd_flag | input | 1 | Read strobe for the cause flag (clear on read) |
| flag_rdata | output | FLAG_W | Reset-cause flag register value |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
The bench builds the block with an 8-bit counter, TAP_MIN of 3, six taps and a 3-cycle reset pulse. Every overflow length from 8 to 256 ticks can then be reached in a few hundred cycles on both time bases, including the clamped select values and the untouched default. The short pulse lets the bench count the request width exactly and then confirm that the mode register has been unlocked again. The same small counter keeps the standby-freeze, strap-forced and restart-timing cases short enough to count tick by tick.

// File: rtl/wdt_guard_pkg.sv
`timescale 1ns/1ps
package wdt_guard_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_OVF  = 2'd1,
      FLT_MODE = 2'd2,
      FLT_KEY  = 2'd3
   } wdt_fault_e;

   typedef struct packed {
      logic locked;
      logic src_sys;
   } mode_flags_t;

   // Limit an overflow select to the last implemented tap.
   function automatic logic [7:0] clamp_sel(input logic [7:0] sel, input int unsigned n);
      if ({24'd0, sel} >= n) return 8'(n - 1);
      return sel;
   endfunction

endpackage

// File: rtl/wdt_guard_tick.sv
`timescale 1ns/1ps
module wdt_guard_tick #(
   parameter bit ALLOW_SYS = 1'b1
) (
   input  logic slow_tick,
   input  logic src_sys,
   input  logic strap_fixed,
   input  logic halt_req,
   input  logic stop_req,
   input  logic busy,
   output logic cnt_en
);
   logic use_sys;
   logic frozen;

   if (ALLOW_SYS) begin : g_sel
      assign use_sys = src_sys & ~strap_fixed;
   end else begin : g_slow_only
      assign use_sys = 1'b0;
   end

   // standby freezes the count only when the strap lets the slow base stop
   assign frozen = ~strap_fixed & (halt_req | stop_req);
   assign cnt_en = (use_sys | slow_tick) & ~frozen & ~busy;
endmodule

// File: rtl/wdt_guard_cnt.sv
`timescale 1ns/1ps
module wdt_guard_cnt
   import wdt_guard_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned TAP_MIN = 11,
   parameter int unsigned TAP_CNT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf
);
   localparam int unsigned IDX_W = $clog2(TAP_CNT);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_tab [TAP_CNT];
   logic [7:0]       sel_c;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] lim;

   // terminal value of each tap: 2^(TAP_MIN+g) - 1
   for (genvar g = 0; g < TAP_CNT; g++) begin : g_tap
      localparam int unsigned EXP = TAP_MIN + g;
      assign lim_tab[g] = {CNT_W{1'b1}} >> (CNT_W - EXP);
   end

   assign sel_c = clamp_sel(8'(sel), TAP_CNT);
   assign idx   = sel_c[IDX_W-1:0];
   assign lim   = lim_tab[idx];
   // >= also catches a count already past a shorter newly chosen tap
   assign ovf   = en && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (en)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt_guard_ctrl.sv
`timescale 1ns/1ps
module wdt_guard_ctrl
   import wdt_guard_pkg::*;
#(
   parameter int unsigned SEL_W        = 3,
   parameter int unsigned MODE_CLK_BIT = 4,
   parameter logic [7:0]  KEY          = 8'hAC,
   parameter int unsigned RST_PULSE    = 4,
   parameter int unsigned FLAG_W       = 8,
   parameter int unsigned FLAG_BIT     = 4,
   parameter int unsigned DEF_SEL      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  logic              wr_key,
   input  logic [7:0]        wr_data,
   input  logic              rd_flag,
   input  logic              ovf,
   output logic [SEL_W-1:0]  sel,
   output logic              src_sys,
   output logic              busy,
   output logic              key_ok,
   output logic              fault,
   output logic              rst_req,
   output logic [FLAG_W-1:0] flag_vec
);
   localparam int unsigned PW = $clog2(RST_PULSE + 1);

   wdt_fault_e       kind;
   mode_flags_t      mflags_q;
   logic             locked_q;
   logic [SEL_W-1:0] sel_q;
   logic [PW-1:0]    pulse_q;
   logic             flag_q;
   logic             accept;

   assign busy    = (pulse_q != '0);
   assign rst_req = busy;
   assign locked_q = mflags_q.locked;

   // fault priority: overflow, then locked mode write, then bad key
   always_comb begin
      kind = FLT_NONE;
      if (!busy) begin
         if (ovf)                            kind = FLT_OVF;
         else if (wr_mode && locked_q)       kind = FLT_MODE;
         else if (wr_key && wr_data != KEY)  kind = FLT_KEY;
      end
   end

   assign fault  = (kind != FLT_NONE);
   assign key_ok = wr_key && !busy && (wr_data == KEY);
   assign accept = wr_mode && !locked_q && !busy && !fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= SEL_W'(DEF_SEL);
         mflags_q <= '0;
      end else if (fault || busy) begin
         sel_q    <= SEL_W'(DEF_SEL);
         mflags_q <= '0;
      end else if (accept) begin
         sel_q            <= wr_data[SEL_W-1:0];
         mflags_q.src_sys <= wr_data[MODE_CLK_BIT];
         mflags_q.locked  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pulse_q <= '0;
      else if (fault)  pulse_q <= PW'(RST_PULSE);
      else if (busy)   pulse_q <= pulse_q - 1'b1;
   end

   // sticky cause: set wins over a simultaneous read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (fault)   flag_q <= 1'b1;
      else if (rd_flag) flag_q <= 1'b0;
   end

   always_comb begin
      flag_vec           = '0;
      flag_vec[FLAG_BIT] = flag_q;
   end

   assign sel     = sel_q;
   assign src_sys = mflags_q.src_sys;
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned SEL_W        = 3,
   parameter int unsigned TAP_MIN      = 11,
   parameter int unsigned TAP_CNT      = 6,
   parameter int unsigned MODE_CLK_BIT = 4,
   parameter logic [7:0]  KEY          = 8'hAC,
   parameter int unsigned RST_PULSE    = 4,
   parameter int unsigned FLAG_W       = 8,
   parameter int unsigned FLAG_BIT     = 4,
   parameter bit          ALLOW_SYS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              strap_fixed,
   input  logic              halt_req,
   input  logic              stop_req,
   input  logic              wr_mode,
   input  logic              wr_key,
   input  logic [7:0]        wr_data,
   input  logic              rd_flag,
   output logic [FLAG_W-1:0] flag_rdata,
   output logic              rst_req
);
   localparam int unsigned DEF_SEL = TAP_CNT - 1;

   if (TAP_MIN + TAP_CNT - 1 > CNT_W) begin : g_chk_width
      $error("wdt_guard: longest tap exceeds counter width");
   end
   if (TAP_CNT < 2 || TAP_CNT > (1 << SEL_W)) begin : g_chk_taps
      $error("wdt_guard: tap count must fit the select field");
   end
   if (SEL_W > MODE_CLK_BIT || MODE_CLK_BIT > 7) begin : g_chk_fields
      $error("wdt_guard: mode fields overlap or exceed a byte");
   end
   if (FLAG_BIT >= FLAG_W || RST_PULSE < 1 || TAP_MIN < 1) begin : g_chk_misc
      $error("wdt_guard: bad flag position, pulse length or tap base");
   end

   logic [SEL_W-1:0] sel;
   logic             src_sys;
   logic             busy;
   logic             key_ok;
   logic             fault;
   logic             cnt_en;
   logic             ovf;

   wdt_guard_tick #(.ALLOW_SYS(ALLOW_SYS)) u_tick (
      .slow_tick  (slow_tick),
      .src_sys    (src_sys),
      .strap_fixed(strap_fixed),
      .halt_req   (halt_req),
      .stop_req   (stop_req),
      .busy       (busy),
      .cnt_en     (cnt_en)
   );

   wdt_guard_cnt #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .TAP_MIN(TAP_MIN), .TAP_CNT(TAP_CNT)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en),
      .clr(key_ok | fault | busy), .sel(sel), .ovf(ovf)
   );

   wdt_guard_ctrl #(
      .SEL_W(SEL_W), .MODE_CLK_BIT(MODE_CLK_BIT), .KEY(KEY),
      .RST_PULSE(RST_PULSE), .FLAG_W(FLAG_W), .FLAG_BIT(FLAG_BIT),
      .DEF_SEL(DEF_SEL)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_key(wr_key),
      .wr_data(wr_data), .rd_flag(rd_flag), .ovf(ovf), .sel(sel),
      .src_sys(src_sys), .busy(busy), .key_ok(key_ok), .fault(fault),
      .rst_req(rst_req), .flag_vec(flag_rdata)
   );
endmodule

// File: rtl/wdt_guard_chk.sv
`timescale 1ns/1ps
module wdt_guard_chk #(
   parameter int unsigned CNT_W     = 16,
   parameter logic [7:0]  KEY       = 8'hAC,
   parameter int unsigned RST_PULSE = 4,
   parameter int unsigned FLAG_W    = 8,
   parameter int unsigned FLAG_BIT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_req,
   input logic              rd_flag,
   input logic              wr_key,
   input logic              wr_mode,
   input logic              strap_fixed,
   input logic              halt_req,
   input logic              stop_req,
   input logic              locked,
   input logic [7:0]        wr_data,
   input logic [FLAG_W-1:0] flag_rdata,
   input logic [CNT_W-1:0]  cnt
);
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 0;
      else if (rst_req) run_q <= run_q + 1;
      else              run_q <= 0;
   end

   p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_req) |-> run_q == RST_PULSE);

   p_flag_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> flag_rdata[FLAG_BIT]);

   p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && locked && !rst_req) |=> rst_req);

   p_key_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && wr_data == KEY && !rst_req) |=> cnt == '0);

   p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && wr_data != KEY && !rst_req) |=> rst_req);

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!strap_fixed && (halt_req || stop_req) && !rst_req && !wr_key && !wr_mode)
      |=> $stable(cnt));

   p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flag && !rst_req) |=> (!flag_rdata[FLAG_BIT] || $rose(rst_req)));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rdata[FLAG_BIT] && !rd_flag) |=> flag_rdata[FLAG_BIT]);

   p_count_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> cnt == '0);
endmodule

bind wdt_guard wdt_guard_chk #(
   .CNT_W(CNT_W), .KEY(KEY), .RST_PULSE(RST_PULSE),
   .FLAG_W(FLAG_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rd_flag(rd_flag),
   .wr_key(wr_key), .wr_mode(wr_mode), .strap_fixed(strap_fixed),
   .halt_req(halt_req), .stop_req(stop_req), .locked(u_ctrl.locked_q),
   .wr_data(wr_data), .flag_rdata(flag_rdata), .cnt(u_cnt.cnt_q)
);

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
   localparam int CW = 8;
   localparam int TM = 3;
   localparam int TN = 6;
   localparam int RP = 3;
   localparam logic [7:0] KEYV = 8'hAC;

   typedef struct packed {
      logic        wr;
      logic [7:0]  mode;
      logic        sys;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h10, 1'b1, 16'd8},     // sel 0, system clock
      '{1'b1, 8'h02, 1'b0, 16'd32},    // sel 2, slow ticks
      '{1'b1, 8'h15, 1'b1, 16'd256},   // sel 5, longest
      '{1'b1, 8'h17, 1'b1, 16'd256},   // sel 7 clamps to 5
      '{1'b0, 8'h00, 1'b0, 16'd256},   // no write: default
      '{1'b1, 8'hE1, 1'b0, 16'd16},    // high bits ignored
      '{1'b1, 8'h13, 1'b1, 16'd64}     // sel 3
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_tick = 1'b0, strap_fixed = 1'b0, halt_req = 1'b0, stop_req = 1'b0;
   logic wr_mode = 1'b0, wr_key = 1'b0, rd_flag = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] flag_rdata;
   logic rst_req;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   wdt_guard #(
      .CNT_W(CW), .SEL_W(3), .TAP_MIN(TM), .TAP_CNT(TN),
      .MODE_CLK_BIT(4), .KEY(KEYV), .RST_PULSE(RP), .FLAG_W(8), .FLAG_BIT(4)
   ) uut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .strap_fixed(strap_fixed),
      .halt_req(halt_req), .stop_req(stop_req), .wr_mode(wr_mode), .wr_key(wr_key),
      .wr_data(wr_data), .rd_flag(rd_flag), .flag_rdata(flag_rdata), .rst_req(rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0; strap_fixed = strap; slow_tick = 1'b0;
      halt_req = 1'b0; stop_req = 1'b0; wr_mode = 1'b0; wr_key = 1'b0; rd_flag = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put_mode(input logic [7:0] d);
      wr_mode = 1'b1; wr_data = d;
      @(negedge clk);
      wr_mode = 1'b0;
   endtask

   task automatic put_key(input logic [7:0] d);
      wr_key = 1'b1; wr_data = d;
      @(negedge clk);
      wr_key = 1'b0;
   endtask

   task automatic tick(input logic sys);
      if (sys) begin
         @(negedge clk);
      end else begin
         repeat (2) @(negedge clk);
         slow_tick = 1'b1;
         @(negedge clk);
         slow_tick = 1'b0;
      end
   endtask

   task automatic measure(input logic sys, output int n);
      n = 0;
      while (rst_req == 1'b0 && n < 300) begin
         tick(sys);
         n++;
      end
   endtask

   task automatic ticks(input logic sys, input int k);
      for (int i = 0; i < k; i++) tick(sys);
   endtask

   initial begin
      #1000000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int n;
      int hi;

      // R1 reset state
      do_reset(1'b0);
      chk("R1 rst_req after reset", int'(rst_req), 0);
      chk("R1 flag after reset", int'(flag_rdata), 0);

      // table walk: R2 interval length, R3 field decode, R1 default select
      for (int v = 0; v < NV; v++) begin
         do_reset(1'b0);
         if (VECS[v].wr) begin
            put_mode(VECS[v].mode);
            put_key(KEYV);
         end
         measure(VECS[v].sys, n);
         chk($sformatf("R2/R3 vector %0d ticks to overflow", v), n, int'(VECS[v].exp));
         chk($sformatf("R2 vector %0d cause flag", v), int'(flag_rdata), 8'h10);
      end

      // R2 pulse width, R9 flag survives pulse, R10 unlock after pulse
      do_reset(1'b0);
      put_mode(8'h10);
      put_key(KEYV);
      measure(1'b1, n);
      chk("R2 sys sel0 overflow", n, 8);
      hi = 0;
      while (rst_req) begin
         hi++;
         @(negedge clk);
      end
      chk("R2 pulse width", hi, RP);
      chk("R9 flag kept through pulse", int'(flag_rdata), 8'h10);
      put_mode(8'h10);
      chk("R10 first write after pulse accepted", int'(rst_req), 0);
      put_key(KEYV);
      measure(1'b1, n);
      chk("R10 new mode in effect after pulse", n, 8);
      while (rst_req) @(negedge clk);

      // R9 read clears
      rd_flag = 1'b1;
      chk("R9 read value", int'(flag_rdata), 8'h10);
      @(negedge clk);
      rd_flag = 1'b0;
      chk("R9 cleared after read", int'(flag_rdata), 0);

      // R4 second mode write
      do_reset(1'b0);
      put_mode(8'h10);
      chk("R4 first write silent", int'(rst_req), 0);
      put_mode(8'h11);
      chk("R4 second write faults", int'(rst_req), 1);
      chk("R4 cause flag", int'(flag_rdata), 8'h10);

      // R6 bad key, R5 good key silent
      do_reset(1'b0);
      put_key(KEYV);
      chk("R5 correct key silent", int'(rst_req), 0);
      put_key(8'h55);
      chk("R6 wrong key faults", int'(rst_req), 1);

      // R5 restart timing
      do_reset(1'b0);
      put_mode(8'h10);
      put_key(KEYV);
      ticks(1'b1, 6);
      chk("R5 before restart", int'(rst_req), 0);
      put_key(KEYV);
      ticks(1'b1, 7);
      chk("R5 seven ticks after restart", int'(rst_req), 0);
      ticks(1'b1, 1);
      chk("R5 eighth tick after restart", int'(rst_req), 1);

      // R8 standby freeze
      do_reset(1'b0);
      put_mode(8'h10);
      put_key(KEYV);
      ticks(1'b1, 4);
      halt_req = 1'b1;
      repeat (20) @(negedge clk);
      chk("R8 frozen in halt", int'(rst_req), 0);
      halt_req = 1'b0; stop_req = 1'b1;
      repeat (20) @(negedge clk);
      chk("R8 frozen in stop", int'(rst_req), 0);
      stop_req = 1'b0;
      ticks(1'b1, 3);
      chk("R8 resumed count short", int'(rst_req), 0);
      ticks(1'b1, 1);
      chk("R8 resumed count reaches limit", int'(rst_req), 1);

      // R7 strap forces slow base and ignores standby
      do_reset(1'b1);
      put_mode(8'h10);
      put_key(KEYV);
      repeat (20) @(negedge clk);
      chk("R7 system clock ignored", int'(rst_req), 0);
      halt_req = 1'b1; stop_req = 1'b1;
      ticks(1'b0, 7);
      chk("R7 slow ticks count in standby", int'(rst_req), 0);
      ticks(1'b0, 1);
      chk("R7 overflow on slow tick 8", int'(rst_req), 1);
      halt_req = 1'b0; stop_req = 1'b0;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule